// File: doc/BRIEF.md
# Multi-Mode Configurable I/O Port

This block is an eight-pin port that sits beside a small microcontroller. Each pin can serve as a register-controlled general-purpose pin, as the output of an internal logic macrocell gated by a product-term enable, or as a driver for address bits held from a multiplexed address/data bus. Software chooses the function of each pin at run time through three writable registers (function select, direction, output value). A fourth, read-only location returns the synchronized level seen at the pins.

The port also holds the bus address. At the end of each address-latch-enable strobe it captures the sixteen address bits: the low byte from the multiplexed lines and the high byte from the dedicated upper lines. One byte of that held address is offered to the pins that are in address-out mode. Build parameters do four things. They name the pins that belong to the logic array. They choose which address byte is driven. They state whether the bus is multiplexed. They remove the function-select register for ports that do not have one.

Top module: `multi_mode_port`

## Requirements
- R1: On a clock edge with rst_n low, the function-select, direction and output-value registers clear to 0. From the next cycle every pad_oe_o bit is 0 until software or the enable term changes it.
- R2: The register window decodes addr_i as follows: 0 = pin level (read-only), 2 = function select, 4 = output value, 6 = direction. A write needs cs_i and wr_i high. Writes to 0, to odd offsets and to offset 0 change nothing, and writes to odd offsets are ignored. A read of an odd offset returns 0, and rdata_o is 0 while cs_i is low.
- R3: A pin whose function-select bit is 0 is a general-purpose pin. It is enabled when its direction bit or its oe_term_i bit is 1, and it drives its output-value bit.
- R4: A pin listed in LOGIC_MASK whose function-select bit is 1 drives its mc_i bit. It is enabled only when both its direction bit and its oe_term_i bit are 1.
- R5: A pin not listed in LOGIC_MASK whose function-select bit is 1 is in address-out mode. It is enabled when its oe_term_i bit is 1, or when its direction and function-select bits are both 1. It drives the matching bit of the chosen address byte.
- R6: On the first clock edge at which ale_i is seen low after being seen high, the held address becomes {ahi_i, ad_i}. At every other edge it is unchanged. It is 0 after reset.
- R7: With ADDR_HIGH=1 and MUX_BUS=1, address-out pins drive address bits 15..8. Otherwise they drive bits 7..0.
- R8: With HAS_CTRL=0, the function-select register reads as 0 and ignores writes. Pins in LOGIC_MASK then behave as in R4, and all other pins behave as in R3.
- R9: A read of offset 0 returns the pad_i value sampled two clock edges earlier, whatever mode each pin is in.
- R10: Any pad_o_o bit whose pad_oe_o bit is 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Register window select |
| wr_i | input | 1 | Write strobe (1 = write) |
| addr_i | input | 3 | Register byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| ale_i | input | 1 | Address-latch-enable strobe |
| ad_i | input | 8 | Multiplexed address/data lines |
| ahi_i | input | 8 | Upper address lines |
| oe_term_i | input | 8 | Per-pin product-term output enable |
| mc_i | input | 8 | Per-pin macrocell output value |
| pad_i | input | 8 | Pin levels |
| pad_o_o | output | 8 | Value driven on each pin |
| pad_oe_o | output | 8 | Per-pin drive enable |

## Verification
The hardest case to reach is an address-out pin that is enabled by the product term alone, with its direction bit still 0, while the held address changes underneath it. This needs a function-select write, then a completed strobe, then the enable term, with the address lines moving between strobes. The bench first drives that order directly. It then runs long random sequences in which writes, strobes, enable terms and pin levels all change every cycle. Three builds run side by side: high byte, forced low byte, and no function-select register. The same stimulus reaches each of them.

// File: rtl/port_pkg.sv
// Shared constants for the multi-mode port: register offsets and widths.
// Assumes an 8-bit register bus with a 3-bit byte offset.
package port_pkg;
    localparam int OFS_W = 3;
    localparam logic [OFS_W-1:0] OFS_PIN  = 3'd0;
    localparam logic [OFS_W-1:0] OFS_FSEL = 3'd2;
    localparam logic [OFS_W-1:0] OFS_VAL  = 3'd4;
    localparam logic [OFS_W-1:0] OFS_DIR  = 3'd6;

    typedef enum logic [1:0] {
        PM_GPIO  = 2'd0,
        PM_LOGIC = 2'd1,
        PM_ADDR  = 2'd2
    } pin_mode_e;
endpackage

// File: rtl/port_sync.sv
// Two-stage synchronizer for the pin levels.
// Assumes pad levels may change at any time relative to clk.
module port_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1, stage2;

    // Shift the pin levels through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_i;
            stage2 <= stage1;
        end
    end

    assign q_o = stage2;
endmodule

// File: rtl/port_regs.sv
// Register window: function select, output value and direction registers, plus the
// read mux that includes the synchronized pin level. Without HAS_CTRL, the
// function select register is absent and reads as zero.
module port_regs
    import port_pkg::*;
#(
    parameter int W        = 8,
    parameter bit HAS_CTRL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_i,
    input  logic             wr_i,
    input  logic [OFS_W-1:0] addr_i,
    input  logic [W-1:0]     wdata_i,
    input  logic [W-1:0]     pin_lvl_i,
    output logic [W-1:0]     fsel_o,
    output logic [W-1:0]     val_o,
    output logic [W-1:0]     dir_o,
    output logic [W-1:0]     rdata_o
);
    logic wr_en;
    logic [W-1:0] val_q, dir_q;

    assign wr_en = cs_i && wr_i;

    // Output value and direction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            dir_q <= '0;
        end else if (wr_en) begin
            if (addr_i == OFS_VAL) val_q <= wdata_i;
            if (addr_i == OFS_DIR) dir_q <= wdata_i;
        end
    end

    generate
        if (HAS_CTRL) begin : g_fsel
            logic [W-1:0] fsel_q;
            // Function select register
            always_ff @(posedge clk) begin
                if (!rst_n)                              fsel_q <= '0;
                else if (wr_en && addr_i == OFS_FSEL)    fsel_q <= wdata_i;
            end
            assign fsel_o = fsel_q;
        end else begin : g_nofsel
            assign fsel_o = '0;
        end
    endgenerate

    assign val_o = val_q;
    assign dir_o = dir_q;

    // Read mux over the register window
    always_comb begin
        rdata_o = '0;
        if (cs_i) begin
            case (addr_i)
                OFS_PIN:  rdata_o = pin_lvl_i;
                OFS_FSEL: rdata_o = fsel_o;
                OFS_VAL:  rdata_o = val_q;
                OFS_DIR:  rdata_o = dir_q;
                default:  rdata_o = '0;
            endcase
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fsel_o == '0 && val_q == '0 && dir_q == '0)); // R1
    AST_PIN_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_i == OFS_PIN) |=> ($stable(fsel_o) && $stable(val_q) && $stable(dir_q))); // R2
endmodule

// File: rtl/port_addr_latch.sv
// Holds the bus address captured at the end of each address-latch-enable strobe.
// The strobe is sampled on clk. Capture happens at the first edge where it is seen low after high.
module port_addr_latch #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ale_i,
    input  logic [W-1:0]   ad_i,
    input  logic [W-1:0]   ahi_i,
    output logic [2*W-1:0] addr_o
);
    logic           ale_q;
    logic           take;
    logic [2*W-1:0] held_q;

    assign take = ale_q && !ale_i;

    // Track strobe and capture the address on its falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_q  <= 1'b0;
            held_q <= '0;
        end else begin
            ale_q <= ale_i;
            if (take) held_q <= {ahi_i, ad_i};
        end
    end

    assign addr_o = held_q;

    AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (held_q == $past({ahi_i, ad_i}))); // R6
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(held_q)); // R6
endmodule

// File: rtl/port_pin_cell.sv
// Output selection for one pin: general-purpose, logic-array output or address-out.
// IS_LOGIC marks a pin owned by the logic array; without HAS_CTRL such a pin
// is always in logic mode and the others are always general-purpose.
module port_pin_cell
    import port_pkg::*;
#(
    parameter bit HAS_CTRL = 1'b1,
    parameter bit IS_LOGIC = 1'b0
) (
    input  logic fsel_i,
    input  logic dir_i,
    input  logic val_i,
    input  logic oe_term_i,
    input  logic mc_i,
    input  logic abit_i,
    output logic pad_o,
    output logic pad_oe
);
    localparam bit CAN_ADDR = HAS_CTRL && !IS_LOGIC;

    pin_mode_e mode;
    logic      en, v;

    // Decide the pin's function
    always_comb begin
        if (CAN_ADDR && fsel_i)                       mode = PM_ADDR;
        else if (IS_LOGIC && (fsel_i || !HAS_CTRL))   mode = PM_LOGIC;
        else                                          mode = PM_GPIO;
    end

    // Enable and value per function
    always_comb begin
        case (mode)
            PM_ADDR: begin
                en = oe_term_i || (dir_i && fsel_i);
                v  = abit_i;
            end
            PM_LOGIC: begin
                en = dir_i && oe_term_i;
                v  = mc_i;
            end
            default: begin
                en = dir_i || oe_term_i;
                v  = val_i;
            end
        endcase
    end

    assign pad_oe = en;
    assign pad_o  = en & v;
endmodule

// File: rtl/multi_mode_port.sv
// Multi-mode I/O port top: register window, address latch, pin synchronizer and
// one output-selection cell per pin. MUX_BUS=0 forces the low address byte.
module multi_mode_port
    import port_pkg::*;
#(
    parameter int           W          = 8,
    parameter bit           HAS_CTRL   = 1'b1,
    parameter logic [W-1:0] LOGIC_MASK = 8'h0F,
    parameter bit           ADDR_HIGH  = 1'b0,
    parameter bit           MUX_BUS    = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_i,
    input  logic             wr_i,
    input  logic [OFS_W-1:0] addr_i,
    input  logic [W-1:0]     wdata_i,
    output logic [W-1:0]     rdata_o,
    input  logic             ale_i,
    input  logic [W-1:0]     ad_i,
    input  logic [W-1:0]     ahi_i,
    input  logic [W-1:0]     oe_term_i,
    input  logic [W-1:0]     mc_i,
    input  logic [W-1:0]     pad_i,
    output logic [W-1:0]     pad_o_o,
    output logic [W-1:0]     pad_oe_o
);
    localparam bit USE_HIGH = ADDR_HIGH && MUX_BUS;

    logic [W-1:0]   pin_lvl, fsel, val, dir, abyte;
    logic [2*W-1:0] held_addr;

    port_sync #(.W(W)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pad_i), .q_o(pin_lvl)
    );

    port_regs #(.W(W), .HAS_CTRL(HAS_CTRL)) u_regs (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .wr_i(wr_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .pin_lvl_i(pin_lvl), .fsel_o(fsel), .val_o(val),
        .dir_o(dir), .rdata_o(rdata_o)
    );

    port_addr_latch #(.W(W)) u_alat (
        .clk(clk), .rst_n(rst_n), .ale_i(ale_i), .ad_i(ad_i), .ahi_i(ahi_i),
        .addr_o(held_addr)
    );

    generate
        if (USE_HIGH) begin : g_hi
            assign abyte = held_addr[2*W-1:W];
        end else begin : g_lo
            assign abyte = held_addr[W-1:0];
        end

        for (genvar i = 0; i < W; i++) begin : g_pin
            port_pin_cell #(.HAS_CTRL(HAS_CTRL), .IS_LOGIC(LOGIC_MASK[i])) u_cell (
                .fsel_i(fsel[i]), .dir_i(dir[i]), .val_i(val[i]),
                .oe_term_i(oe_term_i[i]), .mc_i(mc_i[i]), .abit_i(abyte[i]),
                .pad_o(pad_o_o[i]), .pad_oe(pad_oe_o[i])
            );
        end
    endgenerate

    logic [W-1:0] gpio_pins;
    assign gpio_pins = HAS_CTRL ? ~fsel : ~LOGIC_MASK;

    AST_QUIET_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_o_o & ~pad_oe_o) == '0); // R10
    AST_GPIO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_o_o ^ val) & pad_oe_o & gpio_pins) == '0); // R3
    AST_GPIO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe_o ^ (dir | oe_term_i)) & gpio_pins) == '0); // R3
endmodule

// File: tb/tb_multi_mode_port.sv
// Bench: behavioural reference model updated on each rising edge and compared
// with three builds of the port on each falling edge.
module tb_multi_mode_port;
    localparam logic [7:0] MASK = 8'h0F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 0, wr = 0, ale = 0;
    logic [2:0] addr = 0;
    logic [7:0] wdata = 0, ad = 0, ahi = 0, oet = 0, mc = 0, pad = 0;

    logic [7:0] rd_a, po_a, oe_a, rd_b, po_b, oe_b, rd_c, po_c, oe_c;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #5 clk = ~clk;

    multi_mode_port #(.HAS_CTRL(1'b1), .LOGIC_MASK(MASK), .ADDR_HIGH(1'b1), .MUX_BUS(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rd_a), .ale_i(ale), .ad_i(ad), .ahi_i(ahi), .oe_term_i(oet), .mc_i(mc),
        .pad_i(pad), .pad_o_o(po_a), .pad_oe_o(oe_a));

    multi_mode_port #(.HAS_CTRL(1'b1), .LOGIC_MASK(MASK), .ADDR_HIGH(1'b1), .MUX_BUS(1'b0)) dut_lo (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rd_b), .ale_i(ale), .ad_i(ad), .ahi_i(ahi), .oe_term_i(oet), .mc_i(mc),
        .pad_i(pad), .pad_o_o(po_b), .pad_oe_o(oe_b));

    multi_mode_port #(.HAS_CTRL(1'b0), .LOGIC_MASK(MASK), .ADDR_HIGH(1'b0), .MUX_BUS(1'b1)) dut_nc (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rd_c), .ale_i(ale), .ad_i(ad), .ahi_i(ahi), .oe_term_i(oet), .mc_i(mc),
        .pad_i(pad), .pad_o_o(po_c), .pad_oe_o(oe_c));

    // Reference model state
    logic [7:0]  m_fsel = 0, m_val = 0, m_dir = 0;
    logic [15:0] m_addr = 0;
    logic        m_ale_prev = 0;
    logic [7:0]  m_pinq[$] = '{8'h00, 8'h00};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_fsel = 0; m_val = 0; m_dir = 0; m_addr = 0; m_ale_prev = 0;
            m_pinq = '{8'h00, 8'h00};
        end else begin
            if (cs && wr) begin
                if (addr == 3'd2) m_fsel = wdata;
                if (addr == 3'd4) m_val  = wdata;
                if (addr == 3'd6) m_dir  = wdata;
            end
            if (m_ale_prev && !ale) m_addr = {ahi, ad};
            m_ale_prev = ale;
            m_pinq.push_back(pad);
            void'(m_pinq.pop_front());
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare one build against the model
    task automatic cmp(input string name, input bit hc, input bit hi_byte,
                       input logic [7:0] rd, input logic [7:0] po, input logic [7:0] oe);
        logic [7:0] ab;
        logic [7:0] er;
        string rtag;
        ab = hi_byte ? m_addr[15:8] : m_addr[7:0];
        er = 0; rtag = "R2";
        if (cs) begin
            case (addr)
                3'd0: begin er = m_pinq[0]; rtag = "R9"; end
                3'd2: begin er = hc ? m_fsel : 8'h00; if (!hc) rtag = "R8"; end
                3'd4: er = m_val;
                3'd6: er = m_dir;
                default: er = 0;
            endcase
        end
        chk({rtag, " rdata ", name}, rd, er);
        for (int i = 0; i < 8; i++) begin
            logic en, v;
            string t;
            if (hc && m_fsel[i] && !MASK[i]) begin
                en = oet[i] | m_dir[i]; v = ab[i]; t = "R5 R7";
            end else if (MASK[i] && (!hc || m_fsel[i])) begin
                en = m_dir[i] & oet[i]; v = mc[i]; t = hc ? "R4" : "R8";
            end else begin
                en = m_dir[i] | oet[i]; v = m_val[i]; t = hc ? "R3" : "R8";
            end
            chk($sformatf("%s R10 pin%0d %s", t, i, name), {6'd0, oe[i], po[i]}, {6'd0, en, en & v});
        end
    endtask

    task automatic compare_all();
        cmp("dut", 1'b1, 1'b1, rd_a, po_a, oe_a);
        cmp("dut_lo", 1'b1, 1'b0, rd_b, po_b, oe_b);
        cmp("dut_nc", 1'b0, 1'b0, rd_c, po_c, oe_c);
    endtask

    task automatic step(input logic c, input logic w, input logic [2:0] a, input logic [7:0] d,
                        input logic al, input logic [7:0] lo, input logic [7:0] hi,
                        input logic [7:0] o, input logic [7:0] m, input logic [7:0] p);
        cs = c; wr = w; addr = a; wdata = d; ale = al; ad = lo; ahi = hi;
        oet = o; mc = m; pad = p;
        @(negedge clk);
        compare_all();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: after reset all pins released and registers zero
        chk("R1 oe dut", oe_a, 8'h00);
        chk("R1 oe dut_nc", oe_c, 8'h00);
        compare_all();
        step(1, 0, 3'd2, 0, 0, 0, 0, 0, 0, 8'h5A); // R1 read of function select
        chk("R1 fsel read", rd_a, 8'h00);
        // R2: write to read-only offset and odd offset ignored
        step(1, 1, 3'd0, 8'hFF, 0, 0, 0, 0, 0, 8'h5A);
        step(1, 1, 3'd3, 8'hFF, 0, 0, 0, 0, 0, 8'h5A);
        step(1, 0, 3'd6, 0, 0, 0, 0, 0, 0, 8'h5A);
        chk("R2 dir unchanged", rd_a, 8'h00);
        // R5/R7: address-out enabled by the term alone, direction 0
        step(1, 1, 3'd2, 8'hFF, 1, 8'hA5, 8'h3C, 0, 0, 8'h5A);
        step(0, 0, 3'd0, 0, 0, 8'hA5, 8'h3C, 8'hF0, 8'h0F, 8'h5A);
        step(0, 0, 3'd0, 0, 0, 8'h11, 8'h22, 8'hF0, 8'h0F, 8'h5A);
        chk("R5 R7 high byte", oe_a & po_a, 8'h30);
        chk("R7 low byte", oe_b & po_b, 8'hA0);
        // R6: new strobe updates held address
        step(0, 0, 3'd0, 0, 1, 8'h11, 8'h22, 8'hF0, 8'h0F, 8'h5A);
        step(0, 0, 3'd0, 0, 0, 8'hC3, 8'hE1, 8'hF0, 8'h0F, 8'h5A);
        step(0, 0, 3'd0, 0, 0, 8'h00, 8'h00, 8'hF0, 8'h0F, 8'h5A);
        chk("R6 held high", po_a & 8'hF0, 8'hE0);
        // R9: pin level read in any mode
        step(1, 0, 3'd0, 0, 0, 0, 0, 0, 0, 8'h5A);
        chk("R9 pin read", rd_a, 8'h5A);
        // Random phase
        for (int n = 0; n < 3000; n++) begin
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, 3'($urandom_range(0, 7)),
                 8'($urandom), $urandom_range(0, 3) == 0, 8'($urandom), 8'($urandom),
                 8'($urandom), 8'($urandom), 8'($urandom));
        end
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule